// File: doc/BRIEF.md
# QRSS Line Test Pattern Generator

This block produces a quasi-random line test pattern for a T1 or E1 transmitter, one symbol per line-clock cycle. A maximal-length shift-register sequence supplies raw bits. In T1 mode, long zero runs are capped by forcing a one. In E1 mode the sequence is shorter and the output is inverted. Each bit is coded as alternate mark inversion on two rails, positive and negative, and a zero sends no pulse on either rail.

Two asynchronous request inputs let test equipment disturb the pattern. A rising edge on the first inverts one data bit. If that bit is a forced one, the error moves to the next bit. A rising edge on the second makes the next mark repeat the polarity of the mark before it, which is a bipolar violation. The pattern-select field turns generation on. Which clock drives the block is chosen outside it.

Top module: `qrss_gen`

## Requirements
- R1: Generation runs only while `pat_sel` equals 2'b10 (bit 1 set, bit 0 clear). At any other value both rails are 0 at every edge. The next time generation is enabled, the sequence starts again from its first bit.
- R2: T1 mode (`e1_mode`=0). Bit n is the bit taken at the (n+1)-th rising edge at which generation is enabled, and it appears on the rails just after that edge. The raw bits r0..r(L-1) are all 1, where L=T1_LEN. After that, r(n) = r(n-L) XOR r(n-T1_TAP), which gives the sequence of x^20+x^17+1 at the defaults. A bit that is not forced is sent as its raw value.
- R3: In T1 mode, a bit preceded by ZERO_MAX consecutive transmitted zeros is transmitted as 1.
- R4: E1 mode (`e1_mode`=1) uses the same recurrence with L=E1_LEN and tap E1_TAP (x^15+x^14+1 at the defaults). The transmitted bit is the inverse of the raw bit, and no bit is forced.
- R5: A rising edge on `err_req_async` inverts exactly one transmitted bit. If the input first reads high at clock edge k, the inverted bit is the one taken at edge k+2. Holding the input steady, high or low, inserts nothing.
- R6: If the bit due to carry a logic error is a forced one, it is sent as 1 and the error inverts the following bit instead.
- R7: Each transmitted 1 puts a one-cycle pulse on exactly one rail. Each 0 puts no pulse on either rail. Marks alternate polarity, and the first mark after enabling is on `line_pos`.
- R8: A rising edge on `bpv_req_async` that first reads high at edge k makes the first mark taken at or after edge k+2 repeat the polarity of the previous mark. If no mark has yet been sent since enabling, that mark is negative. Marks after it alternate again.
- R9: Requests whose edge arrives while generation is disabled are discarded and do not alter the pattern once it is enabled.
- R10: The transmitted E1 pattern repeats with period 2^E1_LEN-1 and carries 2^(E1_LEN-1)-1 marks per period. The T1 pattern repeats with period 2^T1_LEN-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock, one symbol per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| e1_mode | input | 1 | 0 selects T1, 1 selects E1 |
| pat_sel | input | 2 | Pattern select; 2'b10 enables generation |
| err_req_async | input | 1 | Asynchronous logic-error request, rising edge |
| bpv_req_async | input | 1 | Asynchronous bipolar-violation request, rising edge |
| line_pos | output | 1 | Positive-rail mark pulse |
| line_neg | output | 1 | Negative-rail mark pulse |

## Verification
The bench builds the block with T1_LEN=5, T1_TAP=3, E1_LEN=4, E1_TAP=3 and ZERO_MAX=3. These are primitive trinomials with periods of 31 and 15 bits. With these values the zero cap is reached once per T1 period, which is rare at the default sizes. The short periods let every error and violation start offset within a whole period be swept in both modes, including an error that lands on a forced one. They also let full-period mark counts and repetition be checked arithmetically.

// File: rtl/qrss_pkg.sv
package qrss_pkg;

    typedef enum logic [1:0] {
        AMI_OFF      = 2'd0,
        AMI_LAST_POS = 2'd1,
        AMI_LAST_NEG = 2'd2
    } ami_state_e;

    localparam logic [1:0] PAT_SEL_QRSS = 2'b10;

endpackage

// File: rtl/qrss_edge_sync.sv
module qrss_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic pulse
);

    logic meta_q;
    logic sync_q;
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign pulse = sync_q & ~prev_q;

    // R5/R8: one request edge gives a single-cycle event
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

endmodule

// File: rtl/qrss_lfsr.sv
module qrss_lfsr #(
    parameter int T1_LEN = 20,
    parameter int T1_TAP = 17,
    parameter int E1_LEN = 15,
    parameter int E1_TAP = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic e1,
    output logic raw_bit
);

    localparam int W = (T1_LEN > E1_LEN) ? T1_LEN : E1_LEN;
    localparam logic [W-1:0] T1_MASK = {W{1'b1}} >> (W - T1_LEN);
    localparam logic [W-1:0] E1_MASK = {W{1'b1}} >> (W - E1_LEN);

    logic [W-1:0] st_q;
    logic         fb;

    always_comb begin
        if (e1) begin
            raw_bit = st_q[E1_LEN-1];
            fb      = st_q[E1_LEN-1] ^ st_q[E1_TAP-1];
        end else begin
            raw_bit = st_q[T1_LEN-1];
            fb      = st_q[T1_LEN-1] ^ st_q[T1_TAP-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '1;
        end else if (!en) begin
            st_q <= '1;
        end else begin
            st_q <= {st_q[W-2:0], fb};
        end
    end

    // R10: the active stages never collapse to all zeros
    a_r10_no_lockup_t1: assert property (@(posedge clk) disable iff (!rst_n)
        !e1 |-> ((st_q & T1_MASK) != '0));
    a_r10_no_lockup_e1: assert property (@(posedge clk) disable iff (!rst_n)
        e1 |-> ((st_q & E1_MASK) != '0));

endmodule

// File: rtl/qrss_shaper.sv
module qrss_shaper #(
    parameter int ZERO_MAX = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic e1,
    input  logic raw_bit,
    input  logic err_pulse,
    output logic bit_out
);

    localparam int ZW = $clog2(ZERO_MAX + 1);

    logic [ZW-1:0] zcnt_q;
    logic          pend_q;
    logic          forced;
    logic          want_err;
    logic          apply_err;
    logic          base_bit;

    always_comb begin
        forced    = !e1 && (zcnt_q == ZW'(ZERO_MAX));
        base_bit  = e1 ? ~raw_bit : (forced | raw_bit);
        want_err  = pend_q | err_pulse;
        apply_err = want_err && !forced;
        bit_out   = base_bit ^ apply_err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zcnt_q <= '0;
            pend_q <= 1'b0;
        end else if (!en) begin
            zcnt_q <= '0;
            pend_q <= 1'b0;
        end else begin
            pend_q <= want_err && forced;
            zcnt_q <= (e1 || bit_out) ? '0 : zcnt_q + ZW'(1);
        end
    end

    // R3: the transmitted zero run never exceeds the cap
    a_r3_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
        zcnt_q <= ZW'(ZERO_MAX));
    // R6: a postponed error is spent on the very next bit
    a_r6_pend_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |=> !pend_q);

endmodule

// File: rtl/qrss_ami.sv
module qrss_ami
    import qrss_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic bit_in,
    input  logic bpv_pulse,
    output logic line_pos,
    output logic line_neg
);

    ami_state_e state_q, state_d;
    logic       vpend_q, vpend_d;
    logic       prev_pos;
    logic       pos_sel;
    logic       want_v;
    logic       pos_d, neg_d;

    // next-state process
    always_comb begin
        unique case (state_q)
            AMI_OFF:      prev_pos = 1'b0;
            AMI_LAST_POS: prev_pos = 1'b1;
            AMI_LAST_NEG: prev_pos = 1'b0;
            default:      prev_pos = 1'b0;
        endcase
        want_v  = vpend_q | bpv_pulse;
        pos_sel = want_v ? prev_pos : !prev_pos;
        if (!en) begin
            state_d = AMI_OFF;
            vpend_d = 1'b0;
        end else if (bit_in) begin
            state_d = pos_sel ? AMI_LAST_POS : AMI_LAST_NEG;
            vpend_d = 1'b0;
        end else begin
            state_d = state_q;
            vpend_d = want_v;
        end
    end

    // output process
    always_comb begin
        pos_d = en && bit_in && pos_sel;
        neg_d = en && bit_in && !pos_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= AMI_OFF;
            vpend_q  <= 1'b0;
            line_pos <= 1'b0;
            line_neg <= 1'b0;
        end else begin
            state_q  <= state_d;
            vpend_q  <= vpend_d;
            line_pos <= pos_d;
            line_neg <= neg_d;
        end
    end

    // R7: never both rails at once
    a_r7_one_rail: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_pos && line_neg));
    // R7: a positive pulse leaves the machine remembering a positive mark
    a_r7_pos_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        line_pos |-> (state_q == AMI_LAST_POS));
    // R1: the idle state never coincides with a pulse
    a_r1_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == AMI_OFF) |-> (!line_pos && !line_neg));

endmodule

// File: rtl/qrss_gen.sv
module qrss_gen
    import qrss_pkg::*;
#(
    parameter int T1_LEN   = 20,
    parameter int T1_TAP   = 17,
    parameter int E1_LEN   = 15,
    parameter int E1_TAP   = 14,
    parameter int ZERO_MAX = 14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       e1_mode,
    input  logic [1:0] pat_sel,
    input  logic       err_req_async,
    input  logic       bpv_req_async,
    output logic       line_pos,
    output logic       line_neg
);

    logic en;
    logic err_pulse;
    logic bpv_pulse;
    logic raw_bit;
    logic tx_bit;

    assign en = (pat_sel == PAT_SEL_QRSS);

    qrss_edge_sync u_err_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (err_req_async),
        .pulse    (err_pulse)
    );

    qrss_edge_sync u_bpv_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (bpv_req_async),
        .pulse    (bpv_pulse)
    );

    qrss_lfsr #(
        .T1_LEN (T1_LEN),
        .T1_TAP (T1_TAP),
        .E1_LEN (E1_LEN),
        .E1_TAP (E1_TAP)
    ) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .e1      (e1_mode),
        .raw_bit (raw_bit)
    );

    qrss_shaper #(
        .ZERO_MAX (ZERO_MAX)
    ) u_shaper (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .e1        (e1_mode),
        .raw_bit   (raw_bit),
        .err_pulse (err_pulse),
        .bit_out   (tx_bit)
    );

    qrss_ami u_ami (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .bit_in    (tx_bit),
        .bpv_pulse (bpv_pulse),
        .line_pos  (line_pos),
        .line_neg  (line_neg)
    );

    // R1: disabled at an edge means silent rails after it
    a_r1_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!line_pos && !line_neg));

endmodule

// File: tb/qrss_gen_tb.sv
`timescale 1ns/1ps
module qrss_gen_tb;

    localparam int TL = 5;
    localparam int TK = 3;
    localparam int EL = 4;
    localparam int EK = 3;
    localparam int ZM = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       e1_mode = 1'b0;
    logic [1:0] pat_sel = 2'b00;
    logic       err_req_async = 1'b0;
    logic       bpv_req_async = 1'b0;
    logic       line_pos, line_neg;

    int checks = 0;
    int errors = 0;
    bit got_bits [0:255];

    always #2 clk = ~clk;

    qrss_gen #(
        .T1_LEN (TL), .T1_TAP (TK), .E1_LEN (EL), .E1_TAP (EK), .ZERO_MAX (ZM)
    ) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .e1_mode       (e1_mode),
        .pat_sel       (pat_sel),
        .err_req_async (err_req_async),
        .bpv_req_async (bpv_req_async),
        .line_pos      (line_pos),
        .line_neg      (line_neg)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    // R1/R9: disabled phase; pre raises both requests while off
    task automatic go_idle(input bit e1, input logic [1:0] sel, input int n, input bit pre);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pat_sel = sel;
            e1_mode = e1;
            err_req_async = pre;
            bpv_req_async = pre;
            if (i > 0) chk("R1 idle rails", {line_pos, line_neg}, 0);
        end
    endtask

    // enabled run with model; starts right after a negedge
    task automatic run_seq(input bit e1, input int n, input int err_at,
                           input int bpv_at, input bit pre);
        bit hist [0:255];
        int L, K, zrun;
        bit raw, bitv, forced, err_pend, bpv_pend, last_pos, newp, apl;
        string tag;
        L = e1 ? EL : TL;
        K = e1 ? EK : TK;
        go_idle(e1, 2'b00, 6, pre);
        zrun = 0; err_pend = 0; bpv_pend = 0; last_pos = 0;
        for (int i = 0; i < n; i++) begin
            pat_sel = 2'b10;
            err_req_async = (err_at >= 0 && i >= err_at && i < err_at + 3) ? 1'b1 : (pre && err_at < 0);
            bpv_req_async = (bpv_at >= 0 && i >= bpv_at && i < bpv_at + 3) ? 1'b1 : (pre && bpv_at < 0);
            @(posedge clk);
            #1;
            raw = (i < L) ? 1'b1 : (hist[i-L] ^ hist[i-K]);
            hist[i] = raw;
            tag = e1 ? "R4" : "R2";
            forced = !e1 && (zrun == ZM);
            if (e1) bitv = ~raw;
            else bitv = forced ? 1'b1 : raw;
            if (forced) tag = "R3";
            if (err_at >= 0 && i == err_at + 2) err_pend = 1;
            apl = 0;
            if (err_pend && !forced) begin
                bitv = ~bitv;
                err_pend = 0;
                apl = 1;
                tag = (i == err_at + 2) ? "R5" : "R6";
            end
            if (pre) tag = {tag, " R9"};
            if (!e1) zrun = bitv ? 0 : zrun + 1;
            if (bpv_at >= 0 && i == bpv_at + 2) bpv_pend = 1;
            if (bitv) begin
                newp = bpv_pend ? last_pos : !last_pos;
                if (bpv_pend) tag = {tag, " R8"};
                else tag = {tag, " R7"};
                bpv_pend = 0;
                last_pos = newp;
                chk(tag, {line_pos, line_neg}, newp ? 2 : 1);
            end else begin
                chk(tag, {line_pos, line_neg}, 0);
            end
            got_bits[i] = line_pos | line_neg;
            @(negedge clk);
        end
    endtask

    initial begin
        #50000000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int marks;
        repeat (3) @(negedge clk);
        chk("R1 reset rails", {line_pos, line_neg}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: every non-enabling select value keeps the rails silent
        go_idle(1'b0, 2'b00, 10, 1'b0);
        go_idle(1'b0, 2'b01, 10, 1'b0);
        go_idle(1'b1, 2'b11, 10, 1'b0);

        // R2/R3/R10: plain T1 over two periods
        run_seq(1'b0, 70, -1, -1, 1'b0);
        for (int i = 5; i < 39; i++) chk("R10 T1 period", got_bits[i], got_bits[i+31]);

        // R4/R10: plain E1 with arithmetic period checks
        run_seq(1'b1, 40, -1, -1, 1'b0);
        marks = 0;
        for (int i = 0; i < 15; i++) marks += got_bits[i];
        chk("R10 E1 marks", marks, 7);
        for (int i = 0; i < 25; i++) chk("R10 E1 period", got_bits[i], got_bits[i+15]);

        // R1/R9: requests while disabled are dropped, restart is clean
        run_seq(1'b0, 20, -1, -1, 1'b1);
        run_seq(1'b1, 20, -1, -1, 1'b1);

        // R5/R6: logic error at every offset of a period
        for (int a = 0; a < 31; a++) run_seq(1'b0, a + 10, a, -1, 1'b0);
        for (int a = 0; a < 15; a++) run_seq(1'b1, a + 10, a, -1, 1'b0);

        // R8: violation at every offset of a period
        for (int a = 0; a < 31; a++) run_seq(1'b0, a + 12, -1, a, 1'b0);
        for (int a = 0; a < 15; a++) run_seq(1'b1, a + 12, -1, a, 1'b0);

        // R5/R8: both requests together
        for (int a = 0; a < 31; a += 5) run_seq(1'b0, a + 12, a, a, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule